// File: doc/BRIEF.md
# Vector Load Address Sequencer

This block turns one vector load command into a stream of per-element word requests toward a set of interleaved, unpipelined memory banks. A single start pulse latches a base word address, a signed stride, an addressing mode, an element count and a full vector of element offsets. The sequencer then walks the elements in ascending order and emits one request per element on a one-hot bank-select bus. Each request carries the word address and the element number.

Every bank can hold only one access at a time for a fixed number of cycles. The sequencer keeps its own record of when each bank frees up. When the bank of the next element is still occupied, it holds that element back, and no later element overtakes it. Returned words come back with their element number and are forwarded as write strobes into a vector register slot. A one-cycle completion pulse follows the final write.

Top module: `vload_seq`

## Requirements
- R1: The address of element i depends on `mode`. Code 0 gives base+i. Code 1 gives base+i*stride, with stride taken as a signed two's-complement word count. Code 2 gives base+offset[i], where offset[i] sits in `idxVec` bits [i*ADDR_W +: ADDR_W]. Code 3 behaves like code 0. All sums wrap modulo 2^ADDR_W.
- R2: A command with length L (0..64) produces exactly L requests. Their element numbers on `bankTag` run 0, 1, ..., L-1 in that order.
- R3: Each request raises exactly one bit of `bankReq`, and that bit is the bank given by `bankAddr` modulo 8 (its low three bits).
- R4: Once a bank has accepted a request on a clock edge, it is not requested again until BANK_LAT edges later.
- R5: The first request is presented in the cycle after the start edge. A request whose bank is free is issued at the next edge. A request whose bank is busy waits until that bank frees, so unit stride and odd strides reach one element per clock when BANK_LAT is at most 8.
- R6: A response (`rspValid`, `rspTag`, `rspData`) appears on `wrEn`, `wrIdx`, `wrData` one cycle later. Every element slot is written once, with the word of its own address.
- R7: `done` is a single-cycle pulse that rises one cycle after the last element's write strobe. `busy` is high from the cycle after start until that pulse, and low afterwards.
- R8: A length of 0 issues no request and pulses `done` one cycle after the start edge.
- R9: A start pulse that arrives while `busy` is high is ignored. The running command keeps its own addresses, length and results.
- R10: After reset, `bankReq`, `wrEn`, `done` and `busy` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command (one-cycle pulse, accepted while idle) |
| mode | input | 2 | Addressing mode code |
| base | input | ADDR_W | Base word address |
| stride | input | ADDR_W | Signed stride in words |
| vecLen | input | LEN_W | Element count, 0..MAX_VL |
| idxVec | input | MAX_VL*ADDR_W | Per-element word offsets for indexed mode |
| bankReq | output | NUM_BANKS | One-hot bank request |
| bankAddr | output | ADDR_W | Word address of the current request |
| bankTag | output | ELEM_W | Element number of the current request |
| rspValid | input | 1 | Returned word valid |
| rspTag | input | ELEM_W | Element number of the returned word |
| rspData | input | DATA_W | Returned word |
| wrEn | output | 1 | Vector register write strobe |
| wrIdx | output | ELEM_W | Element slot written |
| wrData | output | DATA_W | Word written |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |

## Verification
The hardest case to reach is a chain of bank conflicts where stall lengths vary from element to element. The bench must predict the exact edge on which every element is accepted, and it must catch any request made to a bank that is still occupied. To cover this, the stimulus sweeps every stride from -8 to +8, so each run reuses banks at a different spacing. It also sends an indexed vector whose offsets all hit one bank, and an irregular index pattern. The bench predicts each acceptance edge with a greedy per-bank schedule derived from R4 and R5, then compares every request edge and the final completion edge against that schedule.

// File: rtl/vload_pkg.sv
package vload_pkg;

  typedef enum logic [1:0] {
    MODE_UNIT    = 2'd0,
    MODE_STRIDE  = 2'd1,
    MODE_INDEX   = 2'd2,
    MODE_UNIT_B  = 2'd3
  } addrMode_e;

  // strobes from sequencing control to the address/bank datapath
  typedef struct packed {
    logic load;
    logic issue;
    logic finish;
  } seqStrobe_t;

endpackage

// File: rtl/vload_datapath.sv
module vload_datapath
  import vload_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 8,
  parameter int MAX_VL    = 64,
  parameter int BANK_LAT  = 6,
  localparam int LEN_W    = $clog2(MAX_VL + 1),
  localparam int ELEM_W   = $clog2(MAX_VL),
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = (BANK_LAT > 1) ? $clog2(BANK_LAT) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobe_t               strobe,
  input  logic [1:0]               mode,
  input  logic [ADDR_W-1:0]        base,
  input  logic [ADDR_W-1:0]        stride,
  input  logic [LEN_W-1:0]         vecLen,
  input  logic [MAX_VL*ADDR_W-1:0] idxVec,
  input  logic                     rspValid,
  input  logic [ELEM_W-1:0]        rspTag,
  input  logic [DATA_W-1:0]        rspData,
  output logic                     tgtBusy,
  output logic                     allIssued,
  output logic                     allWritten,
  output logic [NUM_BANKS-1:0]     bankReq,
  output logic [ADDR_W-1:0]        bankAddr,
  output logic [ELEM_W-1:0]        bankTag,
  output logic                     wrEn,
  output logic [ELEM_W-1:0]        wrIdx,
  output logic [DATA_W-1:0]        wrData
);

  logic                     isIndexR;
  logic [ADDR_W-1:0]        baseR;
  logic [ADDR_W-1:0]        strideR;
  logic [LEN_W-1:0]         vlR;
  logic [MAX_VL*ADDR_W-1:0] idxR;
  logic [ADDR_W-1:0]        runAddr;
  logic [LEN_W-1:0]         issCnt;
  logic [LEN_W-1:0]         wrCnt;
  logic [ADDR_W-1:0]        idxWord;
  logic [ADDR_W-1:0]        curAddr;
  logic [BANK_W-1:0]        bankSel;
  logic [NUM_BANKS-1:0]     bankFree;

  // command capture and running address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isIndexR <= 1'b0;
      baseR    <= '0;
      strideR  <= '0;
      vlR      <= '0;
      idxR     <= '0;
      runAddr  <= '0;
      issCnt   <= '0;
    end else if (strobe.load) begin
      isIndexR <= (mode == MODE_INDEX);
      baseR    <= base;
      strideR  <= (mode == MODE_STRIDE) ? stride : ADDR_W'(1);
      vlR      <= vecLen;
      idxR     <= idxVec;
      runAddr  <= base;
      issCnt   <= '0;
    end else if (strobe.issue) begin
      runAddr  <= runAddr + strideR;
      issCnt   <= issCnt + 1'b1;
    end
  end

  always_comb begin
    idxWord   = idxR[int'(issCnt[ELEM_W-1:0]) * ADDR_W +: ADDR_W];
    curAddr   = isIndexR ? (baseR + idxWord) : runAddr;
    bankSel   = curAddr[BANK_W-1:0];
    tgtBusy   = !bankFree[bankSel];
    allIssued = (issCnt == vlR);
    allWritten = (wrCnt == vlR);
    bankAddr  = curAddr;
    bankTag   = issCnt[ELEM_W-1:0];
  end

  // per-bank occupancy timers
  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic [CNT_W-1:0] occCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        occCnt <= '0;
      else if (strobe.issue && bankSel == BANK_W'(b))
        occCnt <= CNT_W'(BANK_LAT - 1);
      else if (occCnt != '0)
        occCnt <= occCnt - 1'b1;
    end
    assign bankFree[b] = (occCnt == '0);
    assign bankReq[b]  = strobe.issue && (bankSel == BANK_W'(b));

    if (BANK_LAT > 1) begin : gGap
      // R4
      bank_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
        bankReq[b] |=> !bankReq[b]);
    end
  end

  // return path into the vector register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn   <= 1'b0;
      wrIdx  <= '0;
      wrData <= '0;
      wrCnt  <= '0;
    end else begin
      wrEn   <= rspValid;
      wrIdx  <= rspTag;
      wrData <= rspData;
      if (strobe.load)
        wrCnt <= '0;
      else if (rspValid)
        wrCnt <= wrCnt + 1'b1;
    end
  end

  // R2
  issue_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|bankReq) |=> !(|bankReq) || (bankTag == $past(bankTag) + ELEM_W'(1)));

  // R2
  issue_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    issCnt <= vlR);

  // R6
  write_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ({1'b0, wrIdx} < vlR));

endmodule

// File: rtl/vload_control.sv
module vload_control
  import vload_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       tgtBusy,
  input  logic       allIssued,
  input  logic       allWritten,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  typedef enum logic {S_IDLE, S_RUN} seqState_e;
  seqState_e state;

  always_comb begin
    strobe        = '0;
    strobe.load   = (state == S_IDLE) && start;
    strobe.issue  = (state == S_RUN) && !allIssued && !tgtBusy;
    strobe.finish = (state == S_RUN) && allWritten;
    busy          = (state == S_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (strobe.load)
        state <= S_RUN;
      else if (strobe.finish)
        state <= S_IDLE;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !allWritten |=> busy);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && start && !allWritten |=> busy && !done);

endmodule

// File: rtl/vload_seq.sv
module vload_seq
  import vload_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 8,
  parameter int MAX_VL    = 64,
  parameter int BANK_LAT  = 6,
  localparam int LEN_W    = $clog2(MAX_VL + 1),
  localparam int ELEM_W   = $clog2(MAX_VL)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [1:0]               mode,
  input  logic [ADDR_W-1:0]        base,
  input  logic [ADDR_W-1:0]        stride,
  input  logic [LEN_W-1:0]         vecLen,
  input  logic [MAX_VL*ADDR_W-1:0] idxVec,
  output logic [NUM_BANKS-1:0]     bankReq,
  output logic [ADDR_W-1:0]        bankAddr,
  output logic [ELEM_W-1:0]        bankTag,
  input  logic                     rspValid,
  input  logic [ELEM_W-1:0]        rspTag,
  input  logic [DATA_W-1:0]        rspData,
  output logic                     wrEn,
  output logic [ELEM_W-1:0]        wrIdx,
  output logic [DATA_W-1:0]        wrData,
  output logic                     busy,
  output logic                     done
);

  seqStrobe_t strobe;
  logic       tgtBusy;
  logic       allIssued;
  logic       allWritten;

  vload_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .tgtBusy    (tgtBusy),
    .allIssued  (allIssued),
    .allWritten (allWritten),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done)
  );

  vload_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_BANKS (NUM_BANKS),
    .MAX_VL    (MAX_VL),
    .BANK_LAT  (BANK_LAT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .mode       (mode),
    .base       (base),
    .stride     (stride),
    .vecLen     (vecLen),
    .idxVec     (idxVec),
    .rspValid   (rspValid),
    .rspTag     (rspTag),
    .rspData    (rspData),
    .tgtBusy    (tgtBusy),
    .allIssued  (allIssued),
    .allWritten (allWritten),
    .bankReq    (bankReq),
    .bankAddr   (bankAddr),
    .bankTag    (bankTag),
    .wrEn       (wrEn),
    .wrIdx      (wrIdx),
    .wrData     (wrData)
  );

  // R8
  empty_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && allWritten) |-> !(|bankReq));

endmodule

// File: tb/sim_vload_seq.sv
module sim_vload_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int NB    = 8;
  localparam int MAXVL = 64;
  localparam int LAT   = 6;
  localparam int LW    = $clog2(MAXVL + 1);
  localparam int EW    = $clog2(MAXVL);
  localparam int BW    = $clog2(NB);

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    start = 1'b0;
  logic [1:0]              mode = '0;
  logic [AW-1:0]           base = '0;
  logic [AW-1:0]           stride = '0;
  logic [LW-1:0]           vecLen = '0;
  logic [MAXVL*AW-1:0]     idxVec = '0;
  logic [NB-1:0]           bankReq;
  logic [AW-1:0]           bankAddr;
  logic [EW-1:0]           bankTag;
  logic                    rspValid = 1'b0;
  logic [EW-1:0]           rspTag = '0;
  logic [DW-1:0]           rspData = '0;
  logic                    wrEn;
  logic [EW-1:0]           wrIdx;
  logic [DW-1:0]           wrData;
  logic                    busy;
  logic                    done;

  vload_seq #(
    .ADDR_W(AW), .DATA_W(DW), .NUM_BANKS(NB), .MAX_VL(MAXVL), .BANK_LAT(LAT)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .base(base),
    .stride(stride), .vecLen(vecLen), .idxVec(idxVec), .bankReq(bankReq),
    .bankAddr(bankAddr), .bankTag(bankTag), .rspValid(rspValid),
    .rspTag(rspTag), .rspData(rspData), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrData(wrData), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int c0     = 0;
  int curVl  = 0;
  int reqCnt = 0;
  int wrCnt  = 0;
  bit active = 1'b0;
  logic [AW-1:0] expAddr [MAXVL];
  int            expT    [MAXVL];
  bit            wrSeen  [MAXVL];
  int            lastBankEdge [NB];

  logic          pv [LAT+1];
  logic [EW-1:0] pt [LAT+1];
  logic [DW-1:0] pd [LAT+1];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] memWord(input logic [AW-1:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // bank model, request monitor and write monitor, all on the falling edge
  initial begin
    for (int j = 0; j <= LAT; j++) begin
      pv[j] = 1'b0; pt[j] = '0; pd[j] = '0;
    end
  end

  always @(negedge clk) begin
    if (active && (|bankReq)) begin
      int tag;
      int edgeNo;
      int bk;
      tag    = int'(bankTag);
      edgeNo = cyc + 1 - c0;
      bk     = int'(bankAddr[BW-1:0]);
      chk($onehot(bankReq) && bankReq[bk], "R3", "one-hot bank select",
          longint'(bankReq), longint'(1 << bk));
      chk(tag == reqCnt, "R2", "element order", tag, reqCnt);
      chk(tag < curVl, "R2", "element within length", tag, curVl - 1);
      if (tag < curVl) begin
        chk(bankAddr == expAddr[tag], "R1", "element address",
            bankAddr, expAddr[tag]);
        chk(edgeNo == expT[tag], "R5", "issue edge", edgeNo, expT[tag]);
      end
      chk(edgeNo - lastBankEdge[bk] >= LAT, "R4", "bank spacing",
          edgeNo - lastBankEdge[bk], LAT);
      lastBankEdge[bk] = edgeNo;
      reqCnt++;
    end
    if (active && wrEn) begin
      int wi;
      wi = int'(wrIdx);
      chk(wi < curVl && !wrSeen[wi], "R6", "fresh slot written", wi, curVl);
      if (wi < curVl) begin
        chk(wrData == memWord(expAddr[wi]), "R6", "written word",
            wrData, memWord(expAddr[wi]));
        wrSeen[wi] = 1'b1;
      end
      wrCnt++;
    end
    for (int j = LAT; j > 0; j--) begin
      pv[j] = pv[j-1]; pt[j] = pt[j-1]; pd[j] = pd[j-1];
    end
    pv[0] = |bankReq;
    pt[0] = bankTag;
    pd[0] = memWord(bankAddr);
    rspValid = pv[LAT];
    rspTag   = pt[LAT];
    rspData  = pd[LAT];
  end

  // idxKind: 0 irregular, 1 all to one bank, 2 reversed
  task automatic runVec(input int md, input int bs, input int st, input int vl,
                        input int idxKind, input bit disturb);
    logic [AW-1:0] idxArr [MAXVL];
    int lastAcc [NB];
    int tPrev;
    int expDone;
    int k;
    for (int i = 0; i < MAXVL; i++) begin
      int v;
      case (idxKind)
        0:       v = (i * 37 + i * i) % 1000;
        1:       v = i * 8;
        default: v = 63 - i;
      endcase
      idxArr[i] = AW'(v);
    end
    for (int b = 0; b < NB; b++) begin
      lastAcc[b] = -1000;
      lastBankEdge[b] = -1000;
    end
    tPrev = 0;
    for (int i = 0; i < MAXVL; i++) begin
      wrSeen[i] = 1'b0;
      expT[i] = 0;
      if (md == 1)      expAddr[i] = AW'(bs + i * st);
      else if (md == 2) expAddr[i] = AW'(bs + int'(idxArr[i]));
      else              expAddr[i] = AW'(bs + i);
    end
    for (int i = 0; i < vl; i++) begin
      int b;
      int t;
      b = int'(expAddr[i][BW-1:0]);
      t = tPrev + 1;
      if (lastAcc[b] + LAT > t) t = lastAcc[b] + LAT;
      expT[i] = t;
      lastAcc[b] = t;
      tPrev = t;
    end
    expDone = (vl == 0) ? 1 : tPrev + LAT + 1;
    curVl = vl; reqCnt = 0; wrCnt = 0;

    @(negedge clk);
    mode = 2'(md); base = AW'(bs); stride = AW'(st); vecLen = LW'(vl);
    for (int i = 0; i < MAXVL; i++) idxVec[i*AW +: AW] = idxArr[i];
    start = 1'b1;
    c0 = cyc + 1;
    active = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7", "busy after start", busy, 1);
    k = cyc - c0;
    while (!done && k < 3000) begin
      if (disturb && k == 2) begin
        start = 1'b1; base = ~base; vecLen = LW'(5); mode = 2'd2; stride = AW'(8);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      k = cyc - c0;
    end
    start = 1'b0;
    chk(k < 3000, "R7", "done reached", k, expDone);
    if (vl == 0)
      chk(k == expDone, "R8", "empty command done edge", k, expDone);
    else
      chk(k == expDone, "R5", "done edge from bank schedule", k, expDone);
    chk(reqCnt == vl, "R2", "request count", reqCnt, vl);
    chk(wrCnt == vl, "R6", "write count", wrCnt, vl);
    if (disturb)
      chk(reqCnt == vl && wrCnt == vl, "R9", "mid-run start ignored", reqCnt, vl);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R7", "single done pulse then idle",
        {done, busy}, 0);
    active = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(bankReq == '0, "R10", "reset bankReq", bankReq, 0);
    chk(wrEn == 1'b0, "R10", "reset wrEn", wrEn, 0);
    chk(done == 1'b0, "R10", "reset done", done, 0);
    chk(busy == 1'b0, "R10", "reset busy", busy, 0);

    runVec(0, 5, 0, 64, 0, 1'b0);      // R5 unit stride, full length
    runVec(0, 16'hFFFC, 0, 9, 0, 1'b0); // R1 wrap
    runVec(3, 200, 0, 12, 0, 1'b0);    // R1 code 3 as unit
    runVec(0, 7, 0, 1, 0, 1'b0);       // R2 single element
    runVec(0, 7, 0, 0, 0, 1'b0);       // R8 empty
    runVec(1, 300, 0, 0, 0, 1'b0);     // R8 empty strided
    for (int s = -8; s <= 8; s++)
      runVec(1, 40 + s * 11, s, 17, 0, 1'b0);   // R4 R5 stride sweep
    runVec(1, 3, 2, 64, 0, 1'b0);      // R4 stride 2 full length
    runVec(2, 100, 0, 64, 0, 1'b0);    // R1 irregular gather
    runVec(2, 9, 0, 40, 1, 1'b0);      // R4 gather into one bank
    runVec(2, 16'hFFF0, 0, 64, 2, 1'b0); // R1 reversed gather, wrap
    runVec(1, 50, 3, 20, 0, 1'b1);     // R9 start while busy
    runVec(0, 1, 0, 10, 0, 1'b1);      // R9 start while busy, unit

    summary();
    $finish;
  end

endmodule